// File: doc/BRIEF.md
# Channel Mode Control Register Bank

This block holds the configuration bytes for a six-channel converter front end and turns them into the per-channel control lines that the analog slices need. Software-side framing logic delivers each register write as an address, a data byte and a write strobe. The bank captures writes on the falling edge of the serial clock. A read port returns any stored byte.

From the stored bytes the block decodes several things. Each channel gets a modulator-reset line, a single-ended/differential selection and a polarity-inversion flag. Each channel also gets a gain code and a power-up flag. Two global divide-code fields are passed on to a companion clock divider. The mode and inversion outputs come from a six-bit channel mask combined with a global enable bit. A channel whose mask bit is clear stays in the default mode (not reset, differential, non-inverted) whatever the enable bit says.

Top module: `chmode_ctrl_bank`

## Requirements
- R1: The bank has eight 8-bit registers at addresses 0 to 7. A write with wr_en_i high stores wr_data_i into register wr_addr_i on the falling edge of clk_i. rd_data_o returns the byte stored at rd_addr_i unchanged and without delay.
- R2: A write with wr_addr_i in 8..15 changes no register. A read from an address in 8..15 returns 0.
- R3: After reset, every register reads 0 except register 1, which reads 8'h0C: the serial-divide field [3:2] holds 2'b11 (slowest rate) and the master-divide field [6:4] holds 3'b000 (divide by one).
- R4: Register 6 holds the channel mask in [5:0], the modulator-reset enable in bit 6 and the single-ended enable in bit 7. mod_rst_o[c] is 1 only when mask bit c and bit 6 are both 1.
- R5: single_end_o[c] is 1 (single-ended) only when mask bit c of register 6 and bit 7 of register 6 are both 1. Otherwise it is 0 (differential).
- R6: Register 7 holds the invert selects in [5:0], a test bit in bit 6 and the invert enable in bit 7. invert_o[c] is 1 only when select bit c and bit 7 are both 1. The test bit is stored and read back but drives no output.
- R7: Registers 3, 4 and 5 each serve channels 2k and 2k+1, where k = register - 3. Bits [2:0] hold the gain of channel 2k and bit 3 its power-up flag. Bits [6:4] hold the gain of channel 2k+1 and bit 7 its power-up flag. gain_o[3c+2:3c] carries the gain of channel c, and pwr_up_o[c] is 1 when channel c is powered up.
- R8: sclk_div_o equals register 1 bits [3:2], and mclk_div_o equals register 1 bits [6:4].
- R9: Driving rst_ni low returns every register, and so every output, to its reset value at once, without a clock edge. After rst_ni rises, the reset is released on the second falling edge of clk_i, and writes are accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; writes are captured on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Byte stored at rd_addr_i, 0 when out of range |
| mod_rst_o | output | 6 | Per-channel modulator reset |
| single_end_o | output | 6 | Per-channel single-ended select (0 = differential) |
| invert_o | output | 6 | Per-channel polarity inversion |
| pwr_up_o | output | 6 | Per-channel power-up flag |
| gain_o | output | 18 | Per-channel 3-bit gain codes, channel c at [3c+2:3c] |
| sclk_div_o | output | 2 | Serial clock divide code |
| mclk_div_o | output | 3 | Master clock divide code |

## Verification
A write presented before a falling edge lands at that edge. Every decoded output and the read port follow the stored bytes through combinational logic, so all results are due half a clock after the write edge. The bench drives inputs just after a rising edge and compares one full clock later, after the intervening falling edge has stored the byte. Reads are combinational, so read checks are made with the write strobe low, a short settle after the address changes. The asynchronous reset check samples the outputs one nanosecond after rst_ni falls, with no clock edge in between.

// File: rtl/chmode_pkg.sv
package chmode_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned BANK_DEPTH  = 8;
  localparam int unsigned CHANNELS    = 6;
  localparam int unsigned GAIN_BITS   = 3;

  // register indices whose contents are decoded
  localparam int unsigned IDX_CLOCK   = 1;
  localparam int unsigned IDX_GAIN0   = 3;
  localparam int unsigned IDX_MODE    = 6;
  localparam int unsigned IDX_INVERT  = 7;

  // clock register fields, read by the companion divider
  localparam int unsigned SDIV_LSB    = 2;
  localparam int unsigned SDIV_BITS   = 2;
  localparam int unsigned MDIV_LSB    = 4;
  localparam int unsigned MDIV_BITS   = 3;
  localparam logic [SDIV_BITS-1:0] SDIV_SLOWEST = 2'b11;
  localparam logic [MDIV_BITS-1:0] MDIV_UNITY   = 3'b000;

  // mode and invert register fields
  localparam int unsigned MODE_RST_BIT = 6;
  localparam int unsigned MODE_SE_BIT  = 7;
  localparam int unsigned INV_TEST_BIT = 6;
  localparam int unsigned INV_EN_BIT   = 7;

  // gain/power nibble layout: two channels per register
  localparam int unsigned CH_PER_BYTE  = 2;
  localparam int unsigned NIBBLE_BITS  = 4;
  localparam int unsigned PWR_OFS      = 3;

  typedef struct packed {
    logic                 mod_rst;
    logic                 single_end;
    logic                 invert;
    logic                 pwr_up;
    logic [GAIN_BITS-1:0] gain;
  } chan_ctl_t;

  function automatic logic [BYTE_W-1:0] reset_byte(input int unsigned idx);
    logic [BYTE_W-1:0] b;
    b = '0;
    if (idx == IDX_CLOCK) begin
      b[SDIV_LSB +: SDIV_BITS] = SDIV_SLOWEST;
      b[MDIV_LSB +: MDIV_BITS] = MDIV_UNITY;
    end
    return b;
  endfunction

endpackage

// File: rtl/chmode_rst_sync.sv
module chmode_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[STAGES-1];

endmodule

// File: rtl/chmode_regfile.sv
module chmode_regfile
  import chmode_pkg::*;
#(
  parameter int unsigned DATA_W   = BYTE_W,
  parameter int unsigned NUM_REGS = BANK_DEPTH,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned FLAT_W  = DATA_W * NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [FLAT_W-1:0] bank_o
);

  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic [DATA_W-1:0] reg_d [NUM_REGS];
  logic [NUM_REGS-1:0] hit;
  logic              addr_ok;
  logic              rd_ok;

  assign addr_ok = (32'(wr_addr_i) < NUM_REGS);
  assign rd_ok   = (32'(rd_addr_i) < NUM_REGS);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_byte(r));

    always_comb begin
      hit[r]   = wr_en_i && addr_ok && (32'(wr_addr_i) == r);
      reg_d[r] = wr_data_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[r] <= RST_VAL;
      end else if (hit[r]) begin
        reg_q[r] <= reg_d[r];
      end
    end

    assign bank_o[r*DATA_W +: DATA_W] = reg_q[r];
  end

  always_comb begin
    if (rd_ok) begin
      rd_data_o = reg_q[rd_addr_i[IDX_W-1:0]];
    end else begin
      rd_data_o = '0;
    end
  end

  logic [FLAT_W-1:0] reset_image;
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      reset_image[r*DATA_W +: DATA_W] = DATA_W'(reset_byte(r));
    end
  end

  p_oob_write_ignored_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_ok) |=> $stable(bank_o));

  p_write_lands_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_ok) |=>
      (bank_o[$past(wr_addr_i[IDX_W-1:0])*DATA_W +: DATA_W] == $past(wr_data_i)));

  p_reset_image_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (bank_o == reset_image));

endmodule

// File: rtl/chmode_chan_decode.sv
module chmode_chan_decode
  import chmode_pkg::*;
#(
  parameter int unsigned DATA_W   = BYTE_W,
  parameter int unsigned NUM_REGS = BANK_DEPTH,
  parameter int unsigned NUM_CH   = CHANNELS,
  parameter int unsigned GAIN_W   = GAIN_BITS,
  localparam int unsigned FLAT_W  = DATA_W * NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAT_W-1:0] bank_i,
  output chan_ctl_t         ctl_o [NUM_CH]
);

  logic [DATA_W-1:0] mode_byte;
  logic [DATA_W-1:0] inv_byte;

  assign mode_byte = bank_i[IDX_MODE   * DATA_W +: DATA_W];
  assign inv_byte  = bank_i[IDX_INVERT * DATA_W +: DATA_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GREG = IDX_GAIN0 + c / CH_PER_BYTE;
    localparam int unsigned GOFS = (c % CH_PER_BYTE) * NIBBLE_BITS;

    logic [DATA_W-1:0] gp_byte;
    logic              sel_mode;
    logic              sel_inv;

    assign gp_byte  = bank_i[GREG * DATA_W +: DATA_W];
    assign sel_mode = mode_byte[c];
    assign sel_inv  = inv_byte[c];

    always_comb begin
      ctl_o[c].mod_rst    = sel_mode & mode_byte[MODE_RST_BIT];
      ctl_o[c].single_end = sel_mode & mode_byte[MODE_SE_BIT];
      ctl_o[c].invert     = sel_inv  & inv_byte[INV_EN_BIT];
      ctl_o[c].pwr_up     = gp_byte[GOFS + PWR_OFS];
      ctl_o[c].gain       = gp_byte[GOFS +: GAIN_W];
    end

    p_mask_gates_mode_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !sel_mode |-> (!ctl_o[c].mod_rst && !ctl_o[c].single_end));

    p_se_needs_enable_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ctl_o[c].single_end |-> mode_byte[MODE_SE_BIT]);

    p_inv_needs_both_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ctl_o[c].invert |-> (sel_inv && inv_byte[INV_EN_BIT]));
  end

endmodule

// File: rtl/chmode_ctrl_bank.sv
module chmode_ctrl_bank
  import chmode_pkg::*;
#(
  parameter int unsigned DATA_W   = BYTE_W,
  parameter int unsigned NUM_REGS = BANK_DEPTH,
  parameter int unsigned NUM_CH   = CHANNELS,
  parameter int unsigned GAIN_W   = GAIN_BITS,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned FLAT_W  = DATA_W * NUM_REGS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [NUM_CH-1:0]        mod_rst_o,
  output logic [NUM_CH-1:0]        single_end_o,
  output logic [NUM_CH-1:0]        invert_o,
  output logic [NUM_CH-1:0]        pwr_up_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [SDIV_BITS-1:0]     sclk_div_o,
  output logic [MDIV_BITS-1:0]     mclk_div_o
);

  logic              rst_sync_n;
  logic [FLAT_W-1:0] bank;
  chan_ctl_t         ctl [NUM_CH];

  chmode_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  chmode_regfile #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .bank_o    (bank)
  );

  chmode_chan_decode #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .NUM_CH   (NUM_CH),
    .GAIN_W   (GAIN_W)
  ) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .bank_i (bank),
    .ctl_o  (ctl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign mod_rst_o[c]                 = ctl[c].mod_rst;
    assign single_end_o[c]              = ctl[c].single_end;
    assign invert_o[c]                  = ctl[c].invert;
    assign pwr_up_o[c]                  = ctl[c].pwr_up;
    assign gain_o[c*GAIN_W +: GAIN_W]   = ctl[c].gain;
  end

  assign sclk_div_o = bank[IDX_CLOCK * DATA_W + SDIV_LSB +: SDIV_BITS];
  assign mclk_div_o = bank[IDX_CLOCK * DATA_W + MDIV_LSB +: MDIV_BITS];

  p_hold_without_write_r7: assert property (@(negedge clk_i) disable iff (!rst_sync_n)
    !wr_en_i |=> ($stable(pwr_up_o) && $stable(gain_o)));

  p_clock_fields_hold_r8: assert property (@(negedge clk_i) disable iff (!rst_sync_n)
    !wr_en_i |=> ($stable(sclk_div_o) && $stable(mclk_div_o)));

  p_oob_read_zero_r2: assert property (@(negedge clk_i) disable iff (!rst_sync_n)
    (32'(rd_addr_i) >= NUM_REGS) |-> (rd_data_o == '0));

endmodule

// File: tb/chmode_ctrl_bank_bench.sv
`timescale 1ns/1ps
module chmode_ctrl_bank_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [3:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [5:0]  mod_rst, single_end, invert, pwr_up;
  logic [17:0] gain;
  logic [1:0]  sclk_div;
  logic [2:0]  mclk_div;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [7:0]  model [8];

  chmode_ctrl_bank u_chmode_ctrl_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mod_rst_o(mod_rst), .single_end_o(single_end), .invert_o(invert),
    .pwr_up_o(pwr_up), .gain_o(gain), .sclk_div_o(sclk_div), .mclk_div_o(mclk_div)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void model_reset();
    for (int r = 0; r < 8; r++) model[r] = 8'h00;
    model[1] = 8'h0C;
  endfunction

  function automatic logic [5:0] e_mod_rst();
    return model[6][5:0] & {6{model[6][6]}};
  endfunction
  function automatic logic [5:0] e_se();
    return model[6][5:0] & {6{model[6][7]}};
  endfunction
  function automatic logic [5:0] e_inv();
    return model[7][5:0] & {6{model[7][7]}};
  endfunction
  function automatic logic [5:0] e_pwr();
    logic [5:0] p;
    for (int c = 0; c < 6; c++) p[c] = model[3 + c/2][(c%2)*4 + 3];
    return p;
  endfunction
  function automatic logic [17:0] e_gain();
    logic [17:0] g;
    for (int c = 0; c < 6; c++) g[c*3 +: 3] = model[3 + c/2][(c%2)*4 +: 3];
    return g;
  endfunction
  function automatic logic [7:0] e_read(input logic [3:0] a);
    return (a < 4'd8) ? model[a[2:0]] : 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R4", "mod_rst", 32'(mod_rst), 32'(e_mod_rst()));
    chk("R5", "single_end", 32'(single_end), 32'(e_se()));
    chk("R6", "invert", 32'(invert), 32'(e_inv()));
    chk("R7", "pwr_up", 32'(pwr_up), 32'(e_pwr()));
    chk("R7", "gain", 32'(gain), 32'(e_gain()));
    chk("R8", "sclk_div", 32'(sclk_div), 32'(model[1][3:2]));
    chk("R8", "mclk_div", 32'(mclk_div), 32'(model[1][6:4]));
  endtask

  task automatic check_read(input logic [3:0] a, input string req);
    rd_addr = a;
    #0.1;
    chk(req, "read", 32'(rd_data), 32'(e_read(a)));
  endtask

  // drive at posedge+1, write lands at the negedge, compare at next posedge+1
  task automatic do_op(input logic we, input logic [3:0] a, input logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (we && a < 4'd8) model[a[2:0]] = d;
    check_outputs();
    check_read(a, (a < 4'd8) ? "R1" : "R2");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    model_reset();
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    logic [3:0] a;
    seed = 32'd1234;
    void'($urandom(seed));
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; rst_n = 1'b0;
    model_reset();
    do_reset();

    // R3: reset state through outputs and every read address
    check_outputs();
    for (int i = 0; i < 8; i++) check_read(4'(i), "R3");

    // R4: reset enable with empty mask keeps default
    do_op(1'b1, 4'd6, 8'h40);
    chk("R4", "mask0 no reset", 32'(mod_rst), 32'h0);
    do_op(1'b1, 4'd6, 8'hFF);
    chk("R4", "all reset", 32'(mod_rst), 32'h3F);
    // R5: single-ended on alternate channels, no modulator reset
    do_op(1'b1, 4'd6, 8'h95);
    chk("R5", "se alternate", 32'(single_end), 32'h15);
    chk("R4", "rst off", 32'(mod_rst), 32'h0);
    do_op(1'b1, 4'd6, 8'h3F);
    chk("R5", "mask without enable", 32'(single_end), 32'h0);
    // R6: test bit and selects without enable
    do_op(1'b1, 4'd7, 8'h4A);
    chk("R6", "no enable", 32'(invert), 32'h0);
    do_op(1'b1, 4'd7, 8'hAA);
    chk("R6", "inverted", 32'(invert), 32'h2A);
    // R7: gain/power nibbles
    do_op(1'b1, 4'd3, 8'hD5);
    do_op(1'b1, 4'd5, 8'h8B);
    chk("R7", "ch0 gain", 32'(gain[2:0]), 32'h5);
    chk("R7", "ch5 power", 32'(pwr_up[5]), 32'h1);
    // R8: clock fields
    do_op(1'b1, 4'd1, 8'h70);
    chk("R8", "sclk", 32'(sclk_div), 32'h0);
    chk("R8", "mclk", 32'(mclk_div), 32'h7);
    // R2: out-of-range writes change nothing
    for (int i = 8; i < 16; i++) do_op(1'b1, 4'(i), 8'hFF);
    for (int i = 0; i < 16; i++) check_read(4'(i), "R2");

    // R9: asynchronous reset with no clock edge
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    model_reset();
    check_outputs();
    check_read(4'd6, "R9");
    check_read(4'd1, "R9");
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    do_op(1'b1, 4'd2, 8'h3C);
    chk("R9", "write after release", 32'(rd_data), 32'h3C);

    // constrained random traffic
    for (int k = 0; k < 400; k++) begin
      a = 4'($urandom_range(15, 0));
      if ($urandom_range(3, 0) != 0) a[3] = 1'b0;
      do_op(($urandom_range(7, 0) != 0), a, 8'($urandom));
      check_read(4'($urandom_range(15, 0)), "R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule